// File: doc/BRIEF.md
# Tile Network Interface Controller

This block connects a reconfigurable tile processor to an on-chip network. It reads a stream of 16-bit command words from the network and acts on each one. A command can write words into the tile's configuration memory, fill a local data memory, read a local data memory back to the network, start the tile in block or streaming mode, wait for the tile to go idle, or reset the computation. Every command word carries a 4-bit opcode in bits [15:12] and a 12-bit argument in bits [11:0]. The configure, load and read commands are followed by a base address word and a length word. The configure and load commands then carry that many data words. The opcodes are 1 configure, 2 load, 3 read, 4 start in block mode, 5 start in streaming mode, 6 wait and 7 reset. Every other opcode is discarded.

The sequencer run line `seq_run` is low whenever memories are written. In block mode, every command except reset is stalled at the network port while the tile runs. This forces the order load, then execute, then retrieve. In streaming mode, network input words go straight to the tile and tile output words go straight to the network until the tile reports completion. When a run completes, the block sends the status word 16'hF000 to the network.

The controller has these states: IDLE, BASE, LEN, CFG, LOAD, RISS, RWAIT, RSEND, STRM and DONE. Its transitions are:
- IDLE goes to BASE on a configure, load or read command.
- IDLE goes to STRM on a streaming start.
- IDLE goes to DONE when the tile finishes a block-mode run.
- BASE goes to LEN.
- LEN goes to CFG, LOAD or RISS. If the length is zero, LEN goes back to IDLE.
- CFG and LOAD return to IDLE after their last data word.
- RISS goes to RWAIT, and RWAIT goes to RSEND.
- RSEND goes back to RISS, or to IDLE after its last word.
- STRM goes to DONE when the tile finishes.
- DONE returns to IDLE once the status word is accepted.

Top module: `tile_ni_ctrl`

## Requirements
- R1: After reset, `seq_run`, `seq_clear`, `net_out_valid`, `cfg_we`, `mem_we` and `mem_rd` are low, and `net_in_ready` is high.
- R2: A configure message writes its N data words to configuration addresses base, base+1, and so on (low ADDR_W bits of the base word). It makes one write per accepted data word and never writes the local memory at the same time.
- R3: Configuration and local-memory writes happen only while `seq_run` is low. While a block-mode run is active, every opcode other than 7 is held with `net_in_ready` low, until the tile reports completion.
- R4: A load message writes its data words to the local memory at consecutive addresses from the base. `mem_sel` equals the low SEL_W bits of the command argument.
- R5: A read message reads N words from the selected local memory, starting at the base. It sends them in address order on the network output. While `net_out_ready` is low, the output word is held stable.
- R6: Opcode 4 raises `seq_run` in the cycle after it is accepted. A `tile_done` pulse during the run lowers `seq_run` and produces exactly one status word 16'hF000.
- R7: After opcode 5, input words are passed to the tile's stream input and tile stream words are passed to the network, in order. This continues until `tile_done`, which ends the run with status word 16'hF000.
- R8: Opcode 7 is accepted even while running. `seq_clear` is high in the cycle it is accepted, and `seq_run` is low in the next cycle. If `tile_done` arrives in that same cycle, the reset wins and no status word is sent.
- R9: `tile_done` has no effect while the tile is not running.
- R10: A length word of zero ends the message with no memory write, and the next command is accepted normally.
- R11: A command word whose opcode is not one of 1 to 7 is discarded. It causes no write, no output and no change to `seq_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| net_in_data | input | WORD_W | Word from the network |
| net_in_valid | input | 1 | Network input word valid |
| net_in_ready | output | 1 | Network input word accepted |
| net_out_data | output | WORD_W | Word to the network |
| net_out_valid | output | 1 | Network output word valid |
| net_out_ready | input | 1 | Network can take the output word |
| cfg_we | output | 1 | Configuration memory write strobe |
| cfg_addr | output | ADDR_W | Configuration memory address |
| cfg_wdata | output | WORD_W | Configuration memory write data |
| mem_sel | output | SEL_W | Local memory select |
| mem_we | output | 1 | Local memory write strobe |
| mem_rd | output | 1 | Local memory read strobe; data is returned in the next cycle |
| mem_addr | output | ADDR_W | Local memory address |
| mem_wdata | output | WORD_W | Local memory write data |
| mem_rdata | input | WORD_W | Local memory read data |
| seq_run | output | 1 | Sequencer run; low means the program counter is frozen |
| seq_clear | output | 1 | Computation reset pulse |
| tile_done | input | 1 | The tile has finished its computation |
| str_in_data | output | WORD_W | Stream word to the tile |
| str_in_valid | output | 1 | Stream word to the tile is valid |
| str_in_ready | input | 1 | The tile takes the stream word |
| str_out_data | input | WORD_W | Stream word from the tile |
| str_out_valid | input | 1 | Stream word from the tile is valid |
| str_out_ready | output | 1 | The network takes the tile's stream word |

## Verification
Two events can fall in the same cycle: completion of a run and acceptance of a reset command. The bench starts a block-mode run. It then presents opcode 7 in the same cycle as a `tile_done` pulse. It checks three things: `seq_clear` is high in that cycle, `seq_run` is low in the next cycle, and no status word appears afterwards. A second overlap puts a load command at the input while a block-mode run is active. That command must stay stalled, and the status word must leave before the load is taken.

// File: rtl/tnic_pkg.sv
package tnic_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_CFG    = 4'h1;
    localparam logic [OP_W-1:0] OPC_LOAD   = 4'h2;
    localparam logic [OP_W-1:0] OPC_READ   = 4'h3;
    localparam logic [OP_W-1:0] OPC_START  = 4'h4;
    localparam logic [OP_W-1:0] OPC_STREAM = 4'h5;
    localparam logic [OP_W-1:0] OPC_WAIT   = 4'h6;
    localparam logic [OP_W-1:0] OPC_RESET  = 4'h7;
    localparam logic [OP_W-1:0] OPC_DONE   = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_BASE, ST_LEN, ST_CFG, ST_LOAD,
        ST_RISS, ST_RWAIT, ST_RSEND, ST_STRM, ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        CMD_DROP, CMD_CFG, CMD_LOAD, CMD_READ,
        CMD_START, CMD_STREAM, CMD_WAIT, CMD_RESET
    } cmd_e;
endpackage

// File: rtl/tnic_decode.sv
module tnic_decode
    import tnic_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            running,
    output cmd_e            kind,
    output logic            allowed
);
    always_comb begin
        case (opcode)
            OPC_CFG:    kind = CMD_CFG;
            OPC_LOAD:   kind = CMD_LOAD;
            OPC_READ:   kind = CMD_READ;
            OPC_START:  kind = CMD_START;
            OPC_STREAM: kind = CMD_STREAM;
            OPC_WAIT:   kind = CMD_WAIT;
            OPC_RESET:  kind = CMD_RESET;
            default:    kind = CMD_DROP;
        endcase
        // block mode: only a reset may enter while the tile runs
        allowed = !running || (kind == CMD_RESET);
    end
endmodule

// File: rtl/tnic_xfer_ctr.sv
module tnic_xfer_ctr #(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_base,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              ld_len,
    input  logic [CNT_W-1:0]  len_in,
    input  logic              inc_addr,
    input  logic              dec_cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            addr  <= '0;
            cnt_q <= '0;
        end else begin
            if (ld_base)       addr <= base_in;
            else if (inc_addr) addr <= addr + 1'b1;
            if (ld_len)        cnt_q <= len_in;
            else if (dec_cnt)  cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tile_ni_ctrl.sv
module tile_ni_ctrl
    import tnic_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 11,
    parameter int SEL_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] net_in_data,
    input  logic              net_in_valid,
    output logic              net_in_ready,
    output logic [WORD_W-1:0] net_out_data,
    output logic              net_out_valid,
    input  logic              net_out_ready,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [WORD_W-1:0] cfg_wdata,
    output logic [SEL_W-1:0]  mem_sel,
    output logic              mem_we,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              seq_run,
    output logic              seq_clear,
    input  logic              tile_done,
    output logic [WORD_W-1:0] str_in_data,
    output logic              str_in_valid,
    input  logic              str_in_ready,
    input  logic [WORD_W-1:0] str_out_data,
    input  logic              str_out_valid,
    output logic              str_out_ready
);
    localparam int ARG_W = WORD_W - OP_W;
    localparam logic [WORD_W-1:0] DONE_WORD = {OPC_DONE, {ARG_W{1'b0}}};

    state_e            state_q, state_d;
    logic              run_q, run_d;
    cmd_e              op_q, kind;
    logic              allowed;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] out_q;
    logic              ctr_clr, ld_base, ld_len, inc_addr, dec_cnt, last;
    logic [ADDR_W-1:0] addr;
    logic              len_zero;

    tnic_decode u_dec (
        .opcode  (net_in_data[WORD_W-1 -: OP_W]),
        .running (run_q),
        .kind    (kind),
        .allowed (allowed)
    );

    tnic_xfer_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .ld_base  (ld_base),
        .base_in  (net_in_data[ADDR_W-1:0]),
        .ld_len   (ld_len),
        .len_in   (net_in_data[CNT_W-1:0]),
        .inc_addr (inc_addr),
        .dec_cnt  (dec_cnt),
        .addr     (addr),
        .last     (last)
    );

    assign len_zero = (net_in_data[CNT_W-1:0] == '0);

    // state and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
            op_q    <= CMD_DROP;
            sel_q   <= '0;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            if (state_q == ST_IDLE && state_d == ST_BASE) begin
                op_q  <= kind;
                sel_q <= net_in_data[SEL_W-1:0];
            end
            if (state_q == ST_RWAIT) out_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            ST_IDLE: begin
                if (net_in_valid && allowed && kind == CMD_RESET) begin
                    run_d = 1'b0;
                end else if (run_q && tile_done) begin
                    run_d   = 1'b0;
                    state_d = ST_DONE;
                end else if (net_in_valid && allowed) begin
                    case (kind)
                        CMD_CFG, CMD_LOAD, CMD_READ: state_d = ST_BASE;
                        CMD_START:  run_d = 1'b1;
                        CMD_STREAM: begin
                            run_d   = 1'b1;
                            state_d = ST_STRM;
                        end
                        default: ;
                    endcase
                end
            end
            ST_BASE: if (net_in_valid) state_d = ST_LEN;
            ST_LEN: begin
                if (net_in_valid) begin
                    if (len_zero)              state_d = ST_IDLE;
                    else if (op_q == CMD_CFG)  state_d = ST_CFG;
                    else if (op_q == CMD_LOAD) state_d = ST_LOAD;
                    else                       state_d = ST_RISS;
                end
            end
            ST_CFG, ST_LOAD: if (net_in_valid && last) state_d = ST_IDLE;
            ST_RISS:  state_d = ST_RWAIT;
            ST_RWAIT: state_d = ST_RSEND;
            ST_RSEND: if (net_out_ready) state_d = last ? ST_IDLE : ST_RISS;
            ST_STRM: begin
                if (tile_done) begin
                    run_d   = 1'b0;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: if (net_out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        net_in_ready  = 1'b0;
        net_out_valid = 1'b0;
        net_out_data  = out_q;
        cfg_we        = 1'b0;
        mem_we        = 1'b0;
        mem_rd        = 1'b0;
        seq_clear     = 1'b0;
        str_in_valid  = 1'b0;
        str_out_ready = 1'b0;
        ctr_clr       = 1'b0;
        ld_base       = 1'b0;
        ld_len        = 1'b0;
        inc_addr      = 1'b0;
        dec_cnt       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                net_in_ready = allowed;
                seq_clear    = net_in_valid && allowed && (kind == CMD_RESET);
                ctr_clr      = seq_clear;
            end
            ST_BASE: begin
                net_in_ready = 1'b1;
                ld_base      = net_in_valid;
            end
            ST_LEN: begin
                net_in_ready = 1'b1;
                ld_len       = net_in_valid;
            end
            ST_CFG: begin
                net_in_ready = 1'b1;
                cfg_we       = net_in_valid;
                inc_addr     = net_in_valid;
                dec_cnt      = net_in_valid;
            end
            ST_LOAD: begin
                net_in_ready = 1'b1;
                mem_we       = net_in_valid;
                inc_addr     = net_in_valid;
                dec_cnt      = net_in_valid;
            end
            ST_RISS: begin
                mem_rd   = 1'b1;
                inc_addr = 1'b1;
            end
            ST_RWAIT: ;
            ST_RSEND: begin
                net_out_valid = 1'b1;
                dec_cnt       = net_out_ready;
            end
            ST_STRM: begin
                str_in_valid  = net_in_valid;
                net_in_ready  = str_in_ready;
                net_out_valid = str_out_valid;
                net_out_data  = str_out_data;
                str_out_ready = net_out_ready;
            end
            ST_DONE: begin
                net_out_valid = 1'b1;
                net_out_data  = DONE_WORD;
            end
            default: ;
        endcase
    end

    assign seq_run     = run_q;
    assign mem_sel     = sel_q;
    assign cfg_addr    = addr;
    assign mem_addr    = addr;
    assign cfg_wdata   = net_in_data;
    assign mem_wdata   = net_in_data;
    assign str_in_data = net_in_data;
endmodule

// File: rtl/tnic_checker.sv
module tnic_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] net_in_data,
    input logic              net_in_valid,
    input logic              net_in_ready,
    input logic [WORD_W-1:0] net_out_data,
    input logic              net_out_valid,
    input logic              net_out_ready,
    input logic              cfg_we,
    input logic              mem_we,
    input logic              seq_run,
    input logic              seq_clear,
    input logic              tile_done,
    input logic              str_in_valid,
    input logic              str_out_valid
);
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || mem_we) |-> !seq_run);

    assert_run_gates_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && net_in_valid && net_in_ready && !str_in_valid)
        |-> net_in_data[WORD_W-1 -: 4] == 4'h7);

    assert_write_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || mem_we) |-> (net_in_valid && net_in_ready && !(cfg_we && mem_we)));

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (net_out_valid && !net_out_ready && !str_out_valid)
        |=> (net_out_valid && $stable(net_out_data)));

    assert_start_needs_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_run) |-> $past(net_in_valid && net_in_ready));

    assert_done_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && tile_done) |=> !seq_run);

    assert_clear_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clear |=> !seq_run);
endmodule

bind tile_ni_ctrl tnic_checker #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .net_in_data   (net_in_data),
    .net_in_valid  (net_in_valid),
    .net_in_ready  (net_in_ready),
    .net_out_data  (net_out_data),
    .net_out_valid (net_out_valid),
    .net_out_ready (net_out_ready),
    .cfg_we        (cfg_we),
    .mem_we        (mem_we),
    .seq_run       (seq_run),
    .seq_clear     (seq_clear),
    .tile_done     (tile_done),
    .str_in_valid  (str_in_valid),
    .str_out_valid (str_out_valid)
);

// File: tb/tb_tile_ni_ctrl.sv
`timescale 1ns/1ps
module tb_tile_ni_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        cfg_we, mem_we, mem_rd, seq_run, seq_clear;
    logic [10:0] cfg_addr, mem_addr;
    logic [15:0] cfg_wdata, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  mem_sel;
    logic        tile_done = 1'b0;
    logic [15:0] str_in_data;
    logic        str_in_valid;
    logic [15:0] str_out_data = '0;
    logic        str_out_valid = 1'b0;
    logic        str_out_ready;

    always #4 clk = ~clk;

    tile_ni_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .net_in_data(in_data), .net_in_valid(in_valid), .net_in_ready(in_ready),
        .net_out_data(out_data), .net_out_valid(out_valid), .net_out_ready(out_ready),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_sel(mem_sel), .mem_we(mem_we), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .seq_run(seq_run), .seq_clear(seq_clear), .tile_done(tile_done),
        .str_in_data(str_in_data), .str_in_valid(str_in_valid), .str_in_ready(1'b1),
        .str_out_data(str_out_data), .str_out_valid(str_out_valid), .str_out_ready(str_out_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cfg_cnt = 0;
    int mem_cnt = 0;
    int cyc = 0;
    logic [15:0] cfg_m [0:2047];
    logic [15:0] lm [0:255];
    logic [3:0]  lm_sel = '0;
    logic [15:0] exp_q [$];
    logic [15:0] str_got [$];
    logic        hold_pend = 1'b0;
    logic [15:0] hold_word = '0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // tile-side memory models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cfg_we) begin cfg_m[cfg_addr] <= cfg_wdata; cfg_cnt <= cfg_cnt + 1; end
        if (mem_we) begin lm[mem_addr[7:0]] <= mem_wdata; lm_sel <= mem_sel; mem_cnt <= mem_cnt + 1; end
        if (mem_rd) mem_rdata <= lm[mem_addr[7:0]];
    end

    // network backpressure pattern
    always @(posedge clk) begin
        #1 out_ready <= (cyc % 3 != 1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !str_out_valid) begin
                check(out_valid && out_data == hold_word, "R5 hold", out_data, hold_word);
            end
            hold_pend = out_valid && !out_ready && !str_out_valid;
            hold_word = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R9/R8 unexpected output", out_data, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R5/R6/R7 output word", out_data, e);
                end
            end
            if (str_in_valid) str_got.push_back(str_in_data);
        end
    end

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic tile_send(input logic [15:0] w);
        exp_q.push_back(w);
        @(negedge clk);
        str_out_valid = 1'b1;
        str_out_data  = w;
        #1;
        while (!str_out_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 str_out_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tile_done = 1'b1;
        @(negedge clk);
        tile_done = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(!seq_run && !seq_clear, "R1 run/clear", seq_run, 0);
        check(!out_valid && !cfg_we && !mem_we && !mem_rd, "R1 strobes", out_valid, 0);
        check(in_ready, "R1 ready", in_ready, 1);

        // R2 configure: base 0x010, three words
        send(16'h1000); send(16'h0010); send(16'h0003);
        send(16'hA001); send(16'hA002); send(16'hA003);
        repeat (2) @(negedge clk);
        check(cfg_m[16] == 16'hA001 && cfg_m[17] == 16'hA002 && cfg_m[18] == 16'hA003,
              "R2 cfg words", cfg_m[18], 16'hA003);
        check(cfg_cnt == 3 && mem_cnt == 0, "R2 write count", cfg_cnt, 3);

        // R4 load: select 5, base 0x20, four words
        send(16'h2005); send(16'h0020); send(16'h0004);
        for (int i = 0; i < 4; i++) send(16'h5500 + 16'(i));
        repeat (2) @(negedge clk);
        check(lm[32] == 16'h5500 && lm[35] == 16'h5503, "R4 load words", lm[35], 16'h5503);
        check(lm_sel == 4'd5, "R4 select", lm_sel, 5);
        check(mem_cnt == 4, "R4 write count", mem_cnt, 4);

        // R5 read back under backpressure
        for (int i = 0; i < 4; i++) exp_q.push_back(16'h5500 + 16'(i));
        send(16'h3005); send(16'h0020); send(16'h0004);
        drain("R5 read words");

        // R10 zero length
        c0 = mem_cnt;
        send(16'h2001); send(16'h0040); send(16'h0000);
        repeat (3) @(negedge clk); #1;
        check(mem_cnt == c0, "R10 no write", mem_cnt, c0);
        check(in_ready, "R10 idle again", in_ready, 1);

        // R11 unknown opcode, then wait
        send(16'h9ABC); send(16'h6000);
        repeat (3) @(negedge clk); #1;
        check(!seq_run && cfg_cnt == 3 && mem_cnt == c0, "R11 discarded", seq_run, 0);

        // R9 done while idle
        pulse_done();
        repeat (4) @(negedge clk); #1;
        check(!seq_run && exp_q.size() == 0, "R9 done ignored", seq_run, 0);

        // R6 block run; R3 load stalls while running
        send(16'h4000);
        @(negedge clk); #1;
        check(seq_run, "R6 run after start", seq_run, 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'h2003;
        for (int i = 0; i < 4; i++) begin
            #1 check(!in_ready, "R3 stall while running", in_ready, 0);
            @(negedge clk);
        end
        exp_q.push_back(16'hF000);
        tile_done = 1'b1;
        @(negedge clk);
        tile_done = 1'b0;
        #1 check(!seq_run, "R6 run cleared by done", seq_run, 0);
        while (!in_ready) begin @(negedge clk); #1; end
        check(exp_q.size() == 0, "R3 status before load", exp_q.size(), 0);
        @(posedge clk);
        #1 in_valid = 1'b0;
        send(16'h0030); send(16'h0001); send(16'hBEEF);
        repeat (2) @(negedge clk);
        check(lm[48] == 16'hBEEF && lm_sel == 4'd3, "R3 load after run", lm[48], 16'hBEEF);

        // R7 streaming
        send(16'h5000);
        @(negedge clk); #1;
        check(seq_run, "R7 stream running", seq_run, 1);
        send(16'h1111); send(16'h2222); send(16'h3333);
        tile_send(16'h7001); tile_send(16'h7002);
        exp_q.push_back(16'hF000);
        pulse_done();
        drain("R7 stream output");
        check(str_got.size() == 3, "R7 stream count", str_got.size(), 3);
        if (str_got.size() == 3)
            check(str_got[0] == 16'h1111 && str_got[2] == 16'h3333, "R7 stream order", str_got[2], 16'h3333);
        #1 check(!seq_run, "R7 run ends", seq_run, 0);

        // R8 reset and done in the same cycle
        send(16'h4000);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 16'h7000;
        tile_done = 1'b1;
        #1 check(seq_clear && in_ready, "R8 clear pulse", seq_clear, 1);
        @(posedge clk);
        #1 begin in_valid = 1'b0; tile_done = 1'b0; end
        @(negedge clk); #1;
        check(!seq_run, "R8 frozen", seq_run, 0);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 no status word", exp_q.size(), 0);

        // R8 plain reset while running
        send(16'h4000);
        send(16'h7000);
        @(negedge clk); #1;
        check(!seq_run && in_ready, "R8 reset while running", seq_run, 0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule